// File: doc/BRIEF.md
# Sixteen-times baud tick divider

This block divides the system clock by a programmable 16-bit divisor and produces a one-cycle enable pulse, the baud tick. The tick runs at sixteen times the serial bit rate, and the transmit and receive engines beside the block use it. Software loads the divisor through two byte-wide write strobes, one for the upper byte and one for the lower byte. Both strobes share a data bus. A write to either byte takes effect at once: the internal down-counter restarts from the new divisor value.

A second output carries a gated copy of the tick for an external rate monitor. It is active only while the monitor enable input is high. After reset the divisor is zero and the block stays silent until software programs it.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, with no divisor written, `baud_tick` and `mon_tick` stay low.
- R2: The divisor is {upper byte, lower byte}, with the upper byte in bits 15:8. With a nonzero divisor D, `baud_tick` pulses exactly once every D clock cycles.
- R3: With a divisor of 1, `baud_tick` is high on every cycle.
- R4: With a divisor of 0, `baud_tick` never pulses.
- R5: A write to either byte restarts the count. The first tick appears on the D-th cycle after the write cycle, where D is the new divisor, whatever the count was before the write.
- R6: With a divisor of 2 or more, every tick is exactly one cycle wide.
- R7: `mon_tick` equals `baud_tick` while `mon_en` is 1, and is 0 while `mon_en` is 0.
- R8: The largest divisor, 65535, gives its first tick 65535 cycles after the write.
- R9: A write to one byte leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_hi | input | 1 | Write strobe for divisor bits 15:8 |
| wr_lo | input | 1 | Write strobe for divisor bits 7:0 |
| wr_data | input | 8 | Byte written by either strobe |
| mon_en | input | 1 | Enables the monitor copy of the tick |
| baud_tick | output | 1 | One-cycle pulse at sixteen times the baud rate |
| mon_tick | output | 1 | Baud tick gated by `mon_en` |

## Verification
The assertions expect a write strobe to last one cycle per byte. They also expect a write in any cycle to reload the count. They never assume that writes are spaced out, so a rewrite in the middle of a period must still satisfy the reload and range properties. The bench drives every strobe for exactly one cycle, between falling edges. It lets each divisor run long enough to be measured before it writes again, except in the mid-period rewrite case, which tests exactly that timing.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned BYTE_W_DEF = 8;

  typedef enum logic [1:0] {
    CNT_IDLE   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_RELOAD = 2'd2,
    CNT_DEC    = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_d,
  output logic              load
);
  always_comb begin
    div_d = div_q;
    if (wr_hi) div_d[DIV_W-1:BYTE_W] = wr_data;
    if (wr_lo) div_d[BYTE_W-1:0]     = wr_data;
    load = wr_hi | wr_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (load) div_q <= div_d;
  end

  // R9: an upper-byte write keeps the lower byte
  assert_lo_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (div_q[BYTE_W-1:0] == $past(div_q[BYTE_W-1:0])));
  // R9: a lower-byte write keeps the upper byte
  assert_hi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (div_q[DIV_W-1:BYTE_W] == $past(div_q[DIV_W-1:BYTE_W])));
endmodule

// File: rtl/baud_down_cnt.sv
module baud_down_cnt
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  input  logic             load,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  cnt_act_e         act;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (load)                act = CNT_LOAD;
    else if (div_q == '0)    act = CNT_IDLE;
    else if (cnt_q <= ONE)   act = CNT_RELOAD;
    else                     act = CNT_DEC;

    unique case (act)
      CNT_LOAD:   cnt_d = div_d;
      CNT_RELOAD: cnt_d = div_q;
      CNT_DEC:    cnt_d = cnt_q - ONE;
      default:    cnt_d = '0;
    endcase
    cnt_en = (act != CNT_IDLE) || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick = (div_q != '0) && (cnt_q == ONE);

  // R5: any write restarts the count from the new divisor
  assert_reload_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(div_d)));
  // R2: the count never exceeds a programmed divisor
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (cnt_q <= div_q));
  // R4: a zero divisor keeps the tick low
  assert_zero_div_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !load) |=> !tick);
  // R3: a divisor of one ticks every cycle
  assert_div_one_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == ONE && !load) |=> tick);
  // R6: ticks are single-cycle for divisors of two or more
  assert_single_cycle_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > ONE && !load) |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mon_en,
  output logic              baud_tick,
  output logic              mon_tick
);
  logic             rst_sync_n;
  logic [DIV_W-1:0] div_q, div_d;
  logic             load;

  baud_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  baud_div_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .div_q   (div_q),
    .div_d   (div_d),
    .load    (load)
  );

  baud_down_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .div_q (div_q),
    .div_d (div_d),
    .load  (load),
    .tick  (baud_tick)
  );

  assign mon_tick = baud_tick & mon_en;

  // R1: the tick stays low until a divisor has been written after reset
  assert_silent_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_q == '0 && !load) |=> !mon_tick);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_hi, wr_lo, mon_en;
  logic [7:0] wr_data;
  logic       baud_tick, mon_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .mon_en(mon_en),
    .baud_tick(baud_tick), .mon_tick(mon_tick)
  );

  // results of the last measurement window
  int m_count, m_first, m_bad_gap, m_wide, m_mon_count, m_mon_bad;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input bit hi, input logic [7:0] data);
    @(negedge clk);
    wr_hi = hi; wr_lo = !hi; wr_data = data;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  // Sample index 1 is the falling edge that ends the write cycle.
  task automatic measure(input int window, input int period);
    int last;
    bit prev;
    m_count = 0; m_first = -1; m_bad_gap = 0; m_wide = 0;
    m_mon_count = 0; m_mon_bad = 0; last = -1; prev = 1'b0;
    for (int i = 1; i <= window; i++) begin
      if (i > 1) @(negedge clk);
      if (mon_tick !== (baud_tick & mon_en)) m_mon_bad++;
      if (mon_tick) m_mon_count++;
      if (baud_tick) begin
        m_count++;
        if (m_first < 0) m_first = i;
        if (last >= 0 && (i - last) != period) m_bad_gap++;
        if (prev) m_wide++;
        last = i;
      end
      prev = baud_tick;
    end
  endtask

  task automatic t_reset();
    wr_hi = 1'b0; wr_lo = 1'b0; wr_data = 8'h00; mon_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    measure(40, 1);
    check(m_count == 0, "R1 tick after reset", m_count, 0);
    check(m_mon_count == 0, "R1 mon_tick after reset", m_mon_count, 0);
  endtask

  task automatic t_period(input int d, input string req);
    write_byte(1'b1, 8'(d >> 8));
    write_byte(1'b0, 8'(d));
    measure(d * 6, d);
    check(m_first == d, {req, " first tick"}, m_first, d);
    check(m_count == 6 && m_bad_gap == 0, {req, " tick count/gaps"}, m_count, 6);
  endtask

  task automatic t_div_one();
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'h01);
    measure(30, 1);
    check(m_count == 30, "R3 tick every cycle", m_count, 30);
  endtask

  task automatic t_div_zero();
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'h00);
    measure(300, 1);
    check(m_count == 0, "R4 zero divisor silent", m_count, 0);
  endtask

  task automatic t_width();
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'h02);
    measure(40, 2);
    check(m_wide == 0 && m_count == 20, "R6 single-cycle ticks d=2", m_wide, 0);
    write_byte(1'b0, 8'h03);
    measure(60, 3);
    check(m_wide == 0 && m_count == 20, "R6 single-cycle ticks d=3", m_wide, 0);
  endtask

  task automatic t_midway_reload();
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'd10);
    repeat (5) @(negedge clk);
    write_byte(1'b0, 8'd10);
    measure(35, 10);
    check(m_first == 10, "R5 restart mid-period", m_first, 10);
    write_byte(1'b0, 8'd7);
    measure(28, 7);
    check(m_first == 7 && m_count == 4, "R5 restart with new divisor", m_first, 7);
  endtask

  task automatic t_byte_keep();
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'h04);
    write_byte(1'b1, 8'h01);            // 0x0104 = 260
    measure(600, 260);
    check(m_first == 260 && m_count == 2, "R9 upper write keeps lower byte", m_first, 260);
    write_byte(1'b0, 8'h02);            // 0x0102 = 258
    measure(600, 258);
    check(m_first == 258 && m_count == 2, "R9 lower write keeps upper byte", m_first, 258);
  endtask

  task automatic t_monitor();
    write_byte(1'b1, 8'h00);
    write_byte(1'b0, 8'h05);
    mon_en = 1'b1;
    measure(50, 5);
    check(m_mon_count == 10 && m_mon_bad == 0, "R7 monitor enabled", m_mon_count, 10);
    mon_en = 1'b0;
    @(negedge clk);
    measure(50, 5);
    check(m_mon_count == 0 && m_count == 10, "R7 monitor disabled", m_mon_count, 0);
    mon_en = 1'b1;
  endtask

  task automatic t_max();
    write_byte(1'b1, 8'hFF);
    write_byte(1'b0, 8'hFF);
    measure(65536, 65535);
    check(m_first == 65535 && m_count == 1, "R8 max divisor first tick", m_first, 65535);
  endtask

  initial begin
    t_reset();
    t_period(16, "R2 d=16");
    t_period(37, "R2 d=37");
    t_period(300, "R2 d=300");
    t_div_one();
    t_div_zero();
    t_width();
    t_midway_reload();
    t_byte_keep();
    t_monitor();
    t_max();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule